// File: doc/BRIEF.md
# Flash Write-Cycle Qualification Gate

This block stands between the external control pins of a flash-style memory and its command state machine. It decides whether a bus write is real. A write is real when chip-enable and write-enable are both low and output-enable is high. A write that passes every interlock shows up as a single-cycle strobe when write-enable rises. The block also drives a reset that sends the command state machine back to array-read mode. That reset is active at power-on and whenever the supply is too low for writes.

Every control pin first crosses into the system clock domain through a two-flop synchronizer. A counting filter then suppresses short noise pulses on each pin. After that, several interlocks must all agree before a strobe is produced:
- the logical pin combination must be right;
- the low-supply lockout must be released;
- the power-up inhibit must be clear. This inhibit discards a write whose enables were already low when the part came out of reset.

Any interruption of the pin combination, or any lockout event, while the enables are low cancels the pending write. The write then stays cancelled until the enable pair falls again.

Top module: `wi_write_gate`

## Requirements
- R1: While `rst` is high, `wr_strobe` is 0 and `csm_reset` is 1. After `rst` falls, `csm_reset` stays 1 for two more clock edges and follows the synchronized `low_supply` from the third edge on.
- R2: Take a write with `ce_n`=0, `we_n`=0 and `oe_n`=1 held for at least FILT_CYC clock samples, then `we_n` raised while `ce_n` stays 0. It produces exactly one `wr_strobe`, on the FILT_CYC+3rd rising clock edge counted from the first edge that samples `we_n` high.
- R3: A low pulse on `we_n` seen by fewer than FILT_CYC clock samples produces no strobe. A pulse on `oe_n` shorter than FILT_CYC samples during a write does not cancel it.
- R4: `oe_n` low for at least FILT_CYC samples while the enables are low cancels the write. `ce_n` returning high before `we_n` also means no strobe for that write.
- R5: Take a change of `low_supply`. `csm_reset` follows it on the third rising edge after the change is first sampled. While `csm_reset` is 1 no strobe is produced. A write whose low phase overlaps a `low_supply` pulse of even one sample is discarded.
- R6: Once `low_supply` has been released, a new complete write is accepted normally.
- R7: If `ce_n` and `we_n` are both low when `rst` falls, the next `we_n` rising edge produces no strobe. The inhibit is cleared once the filtered `we_n` or `ce_n` has been seen high, and later writes are accepted. With the pins high at reset, the first write is accepted.
- R8: `wr_strobe` is never high on two consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ce_n | input | 1 | Chip-enable pin, active low, asynchronous |
| we_n | input | 1 | Write-enable pin, active low, asynchronous |
| oe_n | input | 1 | Output-enable pin, active low, asynchronous |
| low_supply | input | 1 | Supply below write-lockout level, active high, asynchronous |
| wr_strobe | output | 1 | One-cycle qualified write pulse to the command state machine |
| csm_reset | output | 1 | Returns the command state machine to array-read mode |

## Verification
Inputs change on the falling clock edge, which is counted as index 0. Outputs are sampled on every later falling edge.

A qualified strobe is due at index FILT_CYC+3 after `we_n` is raised. The bench counts strobe samples over a window longer than that and records the index of the first one. This checks absence, the single-cycle width and the exact latency in one pass.

`csm_reset` is due at index 3 after a `low_supply` change, and at index 3 after reset release. The bench checks index 2 for the old value and index 3 for the new one.

Pulse widths are swept over 1 to FILT_CYC+3 samples, so that each side of the filter threshold is covered.

// File: rtl/wi_pkg.sv
package wi_pkg;

    // Bit positions of the control pins inside the packed pin vector.
    localparam int PIN_CE  = 0;
    localparam int PIN_WE  = 1;
    localparam int PIN_OE  = 2;
    localparam int NUM_PIN = 3;

    typedef struct packed {
        logic oe_n;
        logic we_n;
        logic ce_n;
    } ctl_pins_t;

    // Width needed for a counter that reaches value n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wi_sync.sv
module wi_sync #(
    parameter int         W       = 1,
    parameter logic [0:0] RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= {W{RST_VAL}};
            q    <= {W{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wi_glitch_filter.sv
module wi_glitch_filter #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    import wi_pkg::*;

    localparam int CW = cnt_width(CYC);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] run;

    // A new level is taken only after CYC consecutive differing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            run <= '0;
        end else if (d != q) begin
            if (run == LAST) begin
                q   <= d;
                run <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end else begin
            run <= '0;
        end
    end
endmodule

// File: rtl/wi_write_qual.sv
module wi_write_qual (
    input  logic clk,
    input  logic rst,
    input  logic ce_f,
    input  logic we_f,
    input  logic oe_f,
    input  logic vlow_s,
    output logic pu_inh,
    output logic wr_strobe,
    output logic csm_reset
);
    logic we_q, ce_q, armed;
    logic wr_ok, pair_fall, we_rise;
    logic armed_nxt, strobe_nxt;

    always_comb begin
        wr_ok     = ~ce_f & oe_f & ~vlow_s & ~pu_inh;
        pair_fall = ~we_f & ~ce_f & (we_q | ce_q);
        we_rise   = we_f & ~we_q;

        if (!wr_ok)         armed_nxt = 1'b0;
        else if (we_rise)   armed_nxt = 1'b0;
        else if (pair_fall) armed_nxt = 1'b1;
        else                armed_nxt = armed;

        strobe_nxt = we_rise & armed & wr_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q      <= 1'b0;
            ce_q      <= 1'b0;
            pu_inh    <= 1'b1;
            armed     <= 1'b0;
            wr_strobe <= 1'b0;
            csm_reset <= 1'b1;
        end else begin
            we_q      <= we_f;
            ce_q      <= ce_f;
            if (we_f | ce_f) pu_inh <= 1'b0;
            armed     <= armed_nxt;
            wr_strobe <= strobe_nxt;
            csm_reset <= vlow_s;
        end
    end
endmodule

// File: rtl/wi_write_gate.sv
module wi_write_gate #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic low_supply,
    output logic wr_strobe,
    output logic csm_reset
);
    import wi_pkg::*;

    ctl_pins_t            pin_raw;
    logic [NUM_PIN-1:0]   sync_v;
    logic [NUM_PIN-1:0]   filt_v;
    logic                 vlow_s;
    logic                 pu_inh;

    assign pin_raw = '{oe_n: oe_n, we_n: we_n, ce_n: ce_n};

    wi_sync #(.W(NUM_PIN), .RST_VAL(1'b0)) u_sync_pins (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (sync_v)
    );

    // Supply indicator assumes lockout until proven otherwise.
    wi_sync #(.W(1), .RST_VAL(1'b1)) u_sync_vlow (
        .clk (clk),
        .rst (rst),
        .d   (low_supply),
        .q   (vlow_s)
    );

    for (genvar i = 0; i < NUM_PIN; i++) begin : g_filt
        wi_glitch_filter #(.CYC(FILT_CYC)) u_filt (
            .clk (clk),
            .rst (rst),
            .d   (sync_v[i]),
            .q   (filt_v[i])
        );
    end

    wi_write_qual u_qual (
        .clk       (clk),
        .rst       (rst),
        .ce_f      (filt_v[PIN_CE]),
        .we_f      (filt_v[PIN_WE]),
        .oe_f      (filt_v[PIN_OE]),
        .vlow_s    (vlow_s),
        .pu_inh    (pu_inh),
        .wr_strobe (wr_strobe),
        .csm_reset (csm_reset)
    );
endmodule

// File: rtl/wi_write_gate_chk.sv
module wi_write_gate_chk (
    input logic clk,
    input logic rst,
    input logic we_s,
    input logic we_f,
    input logic ce_f,
    input logic pu_inh,
    input logic wr_strobe,
    input logic csm_reset
);
    // R1: reset drives the command state machine reset
    p_reset_csm_r1: assert property (@(posedge clk) rst |=> csm_reset);

    // R8: strobe is a single-cycle pulse
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    // R2: strobe follows a filtered rising edge of write-enable
    p_strobe_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> ($past(we_f) && !$past(we_f, 2)));

    // R3: filtered write-enable only ever takes the synchronized level
    p_filter_follows_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(we_f) |-> (we_f == $past(we_s)));

    // R4: chip-enable was low when the strobe was decided
    p_ce_low_r4: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> !$past(ce_f));

    // R5: no strobe while the command state machine is held in reset
    p_lockout_r5: assert property (@(posedge clk) disable iff (rst)
        csm_reset |-> !wr_strobe);

    // R7: power-up inhibit blocks the strobe
    p_pu_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> !$past(pu_inh));
endmodule

bind wi_write_gate wi_write_gate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .we_s      (sync_v[wi_pkg::PIN_WE]),
    .we_f      (filt_v[wi_pkg::PIN_WE]),
    .ce_f      (filt_v[wi_pkg::PIN_CE]),
    .pu_inh    (pu_inh),
    .wr_strobe (wr_strobe),
    .csm_reset (csm_reset)
);

// File: tb/tb_wi_write_gate.sv
`timescale 1ns/1ps
module tb_wi_write_gate;
    localparam int F   = 3;
    localparam int WIN = F + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b0, we_n = 1'b0, oe_n = 1'b1, low_supply = 1'b0;
    logic wr_strobe, csm_reset;

    int tests = 0, fails = 0;
    int n_str, first_idx;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wi_write_gate #(.FILT_CYC(F)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .low_supply(low_supply), .wr_strobe(wr_strobe), .csm_reset(csm_reset)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance one falling edge and count any strobe seen
    task automatic step();
        @(negedge clk);
        if (wr_strobe) n_str++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // One write: low phase, optional disturbances, we_n rise, observation window.
    task automatic run_write(input int low_len, input int oe_pulse, input int vl_pulse,
                             input bit ce_first);
        n_str = 0; first_idx = -1;
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        idle(low_len);
        if (oe_pulse > 0) begin
            oe_n = 1'b0; idle(oe_pulse); oe_n = 1'b1; idle(F + 2);
        end
        if (vl_pulse > 0) begin
            low_supply = 1'b1; idle(vl_pulse); low_supply = 1'b0; idle(F + 4);
        end
        if (ce_first) begin
            ce_n = 1'b1; idle(F + 2);
        end
        we_n = 1'b1;
        for (int j = 1; j <= WIN; j++) begin
            @(negedge clk);
            if (wr_strobe) begin
                n_str++;
                if (first_idx < 0) first_idx = j;
            end
        end
        ce_n = 1'b1;
        idle(F + 4);
    endtask

    initial begin
        // R1 and R7: pins low through reset
        idle(4);
        chk(wr_strobe == 1'b0, "R1 strobe in reset", wr_strobe, 0);
        chk(csm_reset == 1'b1, "R1 csm_reset in reset", csm_reset, 1);
        rst = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(csm_reset == 1'b1, "R1 csm_reset two edges after release", csm_reset, 1);
        @(negedge clk);
        chk(csm_reset == 1'b0, "R1 csm_reset third edge after release", csm_reset, 0);
        n_str = 0;
        idle(F + 5);
        we_n = 1'b1;
        idle(WIN);
        chk(n_str == 0, "R7 powered-up low enables inhibit first write", n_str, 0);
        ce_n = 1'b1; idle(F + 4);
        run_write(F + 2, 0, 0, 1'b0);
        chk(n_str == 1, "R7 write accepted after inhibit cleared", n_str, 1);

        // R2, R3, R8: sweep the low-phase width around the filter threshold
        for (int w = 1; w <= F + 3; w++) begin
            run_write(w, 0, 0, 1'b0);
            chk(n_str == ((w >= F) ? 1 : 0), "R3 we_n width sweep count", n_str,
                (w >= F) ? 1 : 0);
            if (w >= F) begin
                chk(first_idx == F + 3, "R2 strobe latency", first_idx, F + 3);
                chk(n_str == 1, "R8 strobe single cycle", n_str, 1);
            end
        end

        // R3: short oe_n glitches do not cancel; R4: long ones do
        for (int p = 1; p <= F + 1; p++) begin
            run_write(F + 2, p, 0, 1'b0);
            chk(n_str == ((p < F) ? 1 : 0), "R3/R4 oe_n pulse sweep", n_str,
                (p < F) ? 1 : 0);
        end
        // R4: ce_n released before we_n
        run_write(F + 2, 0, 0, 1'b1);
        chk(n_str == 0, "R4 ce_n high before we_n rise", n_str, 0);

        // R5: csm_reset latency and lockout
        n_str = 0;
        low_supply = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(csm_reset == 1'b0, "R5 csm_reset before latency", csm_reset, 0);
        @(negedge clk);
        chk(csm_reset == 1'b1, "R5 csm_reset asserted at third edge", csm_reset, 1);
        run_write(F + 2, 0, 0, 1'b0);
        chk(n_str == 0, "R5 no strobe while low supply held", n_str, 0);
        chk(csm_reset == 1'b1, "R5 csm_reset held during lockout", csm_reset, 1);
        low_supply = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(csm_reset == 1'b1, "R5 csm_reset release latency", csm_reset, 1);
        @(negedge clk);
        chk(csm_reset == 1'b0, "R5 csm_reset released at third edge", csm_reset, 0);
        // R5: one-sample pulse during the low phase cancels the write
        run_write(F + 2, 0, 1, 1'b0);
        chk(n_str == 0, "R5 write overlapping supply pulse discarded", n_str, 0);
        // R6: fresh write after release
        run_write(F + 2, 0, 0, 1'b0);
        chk(n_str == 1, "R6 write accepted after lockout release", n_str, 1);
        chk(first_idx == F + 3, "R6 latency after release", first_idx, F + 3);

        // R7: reset with pins high, first write accepted
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(3);
        rst = 1'b0;
        n_str = 0;
        idle(F + 6);
        chk(n_str == 0, "R7 no strobe from release of idle pins", n_str, 0);
        run_write(F + 1, 0, 0, 1'b0);
        chk(n_str == 1, "R7 first write with pins high at reset", n_str, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule